// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the programmable state of a small set of hardware debug triggers for a 32-bit core. Software reaches it through one register port: an address, a write enable and write data, with read data returned combinationally. A select register picks which trigger the three per-trigger data windows expose. A capability register and a machine context register are also on the port. The bank stores only legal values. Every write to a trigger window passes through a per-type legalizer, and unsupported field values are replaced by legal ones before they reach the flops.

Each trigger holds three words: a control word, a compare value and a context qualifier. The control words and compare values of all triggers are driven out as flat buses to the matching logic elsewhere in the core. The machine context value is driven out as well. The block contains no state machine. Each register is a plain flop with a legalized next value.

Top module: `trig_csr_bank`

## Requirements
- R1: During and after reset, the select register holds 0. Every control word reads 0x2000_0000 (type 2, all other fields zero). Every compare and context qualifier reads 0, and the machine context register reads 0.
- R2: Address 0x7A0 is the select register. A write is accepted only when the full 32-bit write value is below the trigger count (2). Otherwise the register keeps its value. A read returns the current index, zero-extended.
- R3: Addresses 0x7A1, 0x7A2 and 0x7A3 read the control word, compare value and context qualifier of the selected trigger in the same cycle as the address. A write lands on the next rising clock edge and changes only the selected trigger.
- R4: A control write whose bits 31:28 equal 2 stores 0x2000_0000 | (data & 0x0003_005F). This keeps the access size in bits 17:16, the privilege enables in bits 6, 4 and 3, and execute/store/load in bits 2:0. The debug-only bit 27 always reads 0.
- R5: A control write whose type is 6 stores 0x6000_0000 | (data & 0x0180_005F), plus the size field in bits 19:16 when that field is legal.
- R6: For type 6, the size codes 0, 1, 2, 3 and 5 are kept. Any other code stores size 0.
- R7: A control write whose type is 3 (instruction count) stores 0x3000_0000 | (data & 0x06FF_FEC0). This keeps the count in bits 23:10 and the privilege enables in bits 26, 25, 9, 7 and 6.
- R8: A control write with any type code other than 2, 3 or 6 has no effect.
- R9: A compare-value write stores the full word when the selected trigger is of type 2 or 6. It is ignored when the trigger is of type 3.
- R10: A context-qualifier write keeps bits 31:26 (value) and bit 25. The 3-bit selector in bits 25:23 is folded so that only codes 0 and 4 survive. All bits below 25 read 0.
- R11: Address 0x7A4 always reads 0x0000_0044 (types 2 and 6 supported), whatever trigger is selected. Writes to it have no effect.
- R12: Address 0x7A8 is the machine context register. Its low 6 bits are writable, it reads zero-extended, and it is driven on `mctx_o`.
- R13: `trig_ctrl_o` and `trig_cmp_o` carry trigger i's control word and compare value in bits [32*i+31:32*i].
- R14: Any other address reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_addr_i | input | 12 | Register address |
| csr_we_i | input | 1 | Write enable |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data for `csr_addr_i`, combinational |
| trig_ctrl_o | output | 32*N_TRIG | Stored control words, trigger 0 in the low word |
| trig_cmp_o | output | 32*N_TRIG | Stored compare values, trigger 0 in the low word |
| mctx_o | output | 6 | Machine context value |

## Verification
A wrong stored field shows on the control export one cycle after the offending write, and on the read port as soon as the window is addressed. A select register that takes an out-of-range value, or a write that spills into the unselected trigger, shows when the other trigger is read back after switching the select. A legalizer that passes a forbidden bit shows as extra set bits in the read-back word of that very write. A legalizer that drops a type-3 write, or lets a type-3 compare write through, shows in the next read of the affected window.

// File: rtl/trig_csr_pkg.sv
package trig_csr_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CTX_W  = 6;

    localparam logic [3:0] TYP_ADDR  = 4'd2;
    localparam logic [3:0] TYP_COUNT = 4'd3;
    localparam logic [3:0] TYP_ADDR6 = 4'd6;

    // Bits kept from a write, per trigger type
    localparam logic [31:0] KEEP_ADDR  = 32'h0003_005F;
    localparam logic [31:0] KEEP_ADDR6 = 32'h0180_005F;
    localparam logic [31:0] SIZE_ADDR6 = 32'h000F_0000;
    localparam logic [31:0] KEEP_COUNT = 32'h06FF_FEC0;
    localparam logic [31:0] KEEP_QUAL  = 32'hFE00_0000;

    localparam logic [31:0] CTRL_RESET = {TYP_ADDR, 28'h0};
    localparam logic [31:0] CAP_WORD   = 32'h0000_0044;

    typedef struct packed {
        logic        take;
        logic [31:0] value;
    } legal_t;

    function automatic logic size6_legal(input logic [3:0] code);
        return (code <= 4'd3) || (code == 4'd5);
    endfunction

    function automatic legal_t ctrl_legalize(input logic [31:0] wd);
        legal_t r;
        r.take  = 1'b1;
        r.value = '0;
        unique case (wd[31:28])
            TYP_ADDR:  r.value = {TYP_ADDR, 28'h0} | (wd & KEEP_ADDR);
            TYP_ADDR6: r.value = {TYP_ADDR6, 28'h0} | (wd & KEEP_ADDR6)
                               | (size6_legal(wd[19:16]) ? (wd & SIZE_ADDR6) : 32'h0);
            TYP_COUNT: r.value = {TYP_COUNT, 28'h0} | (wd & KEEP_COUNT);
            default:   r.take  = 1'b0;
        endcase
        return r;
    endfunction

    // Selector bits 25:23 fold to {bit25,00}; only bit 25 survives
    function automatic logic [31:0] qual_legalize(input logic [31:0] wd);
        return wd & KEEP_QUAL;
    endfunction

    function automatic logic takes_compare(input logic [3:0] typ);
        return (typ == TYP_ADDR) || (typ == TYP_ADDR6);
    endfunction

endpackage

// File: rtl/trig_sel_reg.sv
module trig_sel_reg #(
    parameter int unsigned N_TRIG = 2,
    parameter int unsigned IDX_W  = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [31:0]      wdata_i,
    output logic [IDX_W-1:0] sel_o
);
    logic [IDX_W-1:0] sel_q;
    logic             in_range;

    assign in_range = wdata_i < 32'(N_TRIG);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sel_q <= '0;
        end else if (wr_i && in_range) begin
            sel_q <= wdata_i[IDX_W-1:0];
        end
    end

    assign sel_o = sel_q;

    AST_SEL_OOR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && (wdata_i >= 32'(N_TRIG))) |=> $stable(sel_o)); // R2

    AST_SEL_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(sel_o)); // R2

endmodule

// File: rtl/trig_slot.sv
module trig_slot
    import trig_csr_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_ctrl_i,
    input  logic        wr_cmp_i,
    input  logic        wr_qual_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] ctrl_o,
    output logic [31:0] cmp_o,
    output logic [31:0] qual_o
);
    logic [31:0] ctrl_q, cmp_q, qual_q;
    legal_t      ctrl_nx;

    assign ctrl_nx = ctrl_legalize(wdata_i);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_ctrl_i && ctrl_nx.take) begin
            ctrl_q <= ctrl_nx.value;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cmp_q <= '0;
        end else if (wr_cmp_i && takes_compare(ctrl_q[31:28])) begin
            cmp_q <= wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            qual_q <= '0;
        end else if (wr_qual_i) begin
            qual_q <= qual_legalize(wdata_i);
        end
    end

    assign ctrl_o = ctrl_q;
    assign cmp_o  = cmp_q;
    assign qual_o = qual_q;

    AST_TYPE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_o[31:28] == TYP_ADDR) || (ctrl_o[31:28] == TYP_ADDR6)
        || (ctrl_o[31:28] == TYP_COUNT)); // R8

    AST_DMODE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_o[27]); // R4

    AST_QUAL_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        qual_o[24:0] == 25'h0); // R10

    AST_SLOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_ctrl_i || wr_cmp_i || wr_qual_i)
        |=> ($stable(ctrl_o) && $stable(cmp_o) && $stable(qual_o))); // R3

    AST_COUNT_NO_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_cmp_i && ctrl_o[31:28] == TYP_COUNT) |=> $stable(cmp_o)); // R9

endmodule

// File: rtl/trig_rd_mux.sv
module trig_rd_mux
    import trig_csr_pkg::*;
#(
    parameter int unsigned N_TRIG   = 2,
    parameter int unsigned IDX_W    = 1,
    parameter logic [11:0] A_SEL    = 12'h7A0,
    parameter logic [11:0] A_CTRL   = 12'h7A1,
    parameter logic [11:0] A_CMP    = 12'h7A2,
    parameter logic [11:0] A_QUAL   = 12'h7A3,
    parameter logic [11:0] A_CAP    = 12'h7A4,
    parameter logic [11:0] A_MCTX   = 12'h7A8
) (
    input  logic [11:0]          addr_i,
    input  logic [IDX_W-1:0]     sel_i,
    input  logic [32*N_TRIG-1:0] ctrl_i,
    input  logic [32*N_TRIG-1:0] cmp_i,
    input  logic [32*N_TRIG-1:0] qual_i,
    input  logic [CTX_W-1:0]     mctx_i,
    output logic [31:0]          rdata_o
);
    logic [31:0] ctrl_s, cmp_s, qual_s;

    always_comb begin
        ctrl_s = '0;
        cmp_s  = '0;
        qual_s = '0;
        for (int i = 0; i < int'(N_TRIG); i++) begin
            if (sel_i == IDX_W'(i)) begin
                ctrl_s = ctrl_i[32*i +: 32];
                cmp_s  = cmp_i[32*i +: 32];
                qual_s = qual_i[32*i +: 32];
            end
        end
    end

    always_comb begin
        unique case (addr_i)
            A_SEL:   rdata_o = 32'(sel_i);
            A_CTRL:  rdata_o = ctrl_s;
            A_CMP:   rdata_o = cmp_s;
            A_QUAL:  rdata_o = qual_s;
            A_CAP:   rdata_o = CAP_WORD;
            A_MCTX:  rdata_o = 32'(mctx_i);
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/trig_csr_bank.sv
module trig_csr_bank
    import trig_csr_pkg::*;
#(
    parameter int unsigned N_TRIG = 2,
    parameter logic [11:0] A_SEL  = 12'h7A0,
    parameter logic [11:0] A_CTRL = 12'h7A1,
    parameter logic [11:0] A_CMP  = 12'h7A2,
    parameter logic [11:0] A_QUAL = 12'h7A3,
    parameter logic [11:0] A_CAP  = 12'h7A4,
    parameter logic [11:0] A_MCTX = 12'h7A8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [11:0]           csr_addr_i,
    input  logic                  csr_we_i,
    input  logic [31:0]           csr_wdata_i,
    output logic [31:0]           csr_rdata_o,
    output logic [32*N_TRIG-1:0]  trig_ctrl_o,
    output logic [32*N_TRIG-1:0]  trig_cmp_o,
    output logic [CTX_W-1:0]      mctx_o
);
    localparam int unsigned IDX_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1;

    logic [IDX_W-1:0]     sel;
    logic [32*N_TRIG-1:0] qual_flat;
    logic [CTX_W-1:0]     mctx_q;
    logic                 wr_sel, wr_ctrl, wr_cmp, wr_qual, wr_mctx;

    assign wr_sel  = csr_we_i && (csr_addr_i == A_SEL);
    assign wr_ctrl = csr_we_i && (csr_addr_i == A_CTRL);
    assign wr_cmp  = csr_we_i && (csr_addr_i == A_CMP);
    assign wr_qual = csr_we_i && (csr_addr_i == A_QUAL);
    assign wr_mctx = csr_we_i && (csr_addr_i == A_MCTX);

    trig_sel_reg #(.N_TRIG(N_TRIG), .IDX_W(IDX_W)) sel_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_sel),
        .wdata_i (csr_wdata_i),
        .sel_o   (sel)
    );

    for (genvar g = 0; g < int'(N_TRIG); g++) begin : g_slot
        logic hit;
        assign hit = (sel == IDX_W'(g));
        trig_slot slot_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_ctrl_i (wr_ctrl && hit),
            .wr_cmp_i  (wr_cmp && hit),
            .wr_qual_i (wr_qual && hit),
            .wdata_i   (csr_wdata_i),
            .ctrl_o    (trig_ctrl_o[32*g +: 32]),
            .cmp_o     (trig_cmp_o[32*g +: 32]),
            .qual_o    (qual_flat[32*g +: 32])
        );
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mctx_q <= '0;
        end else if (wr_mctx) begin
            mctx_q <= csr_wdata_i[CTX_W-1:0];
        end
    end

    assign mctx_o = mctx_q;

    trig_rd_mux #(
        .N_TRIG (N_TRIG), .IDX_W (IDX_W),
        .A_SEL  (A_SEL),  .A_CTRL(A_CTRL), .A_CMP (A_CMP),
        .A_QUAL (A_QUAL), .A_CAP (A_CAP),  .A_MCTX(A_MCTX)
    ) rd_i (
        .addr_i  (csr_addr_i),
        .sel_i   (sel),
        .ctrl_i  (trig_ctrl_o),
        .cmp_i   (trig_cmp_o),
        .qual_i  (qual_flat),
        .mctx_i  (mctx_q),
        .rdata_o (csr_rdata_o)
    );

    AST_CAP_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == A_CAP) |-> (csr_rdata_o == 32'h0000_0044)); // R11

    AST_MCTX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_mctx |=> $stable(mctx_o)); // R12

    AST_CTRL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == A_CTRL) |-> (csr_rdata_o == trig_ctrl_o[32*sel +: 32])); // R13

endmodule

// File: tb/trig_csr_bank_tb_top.sv
module trig_csr_bank_tb_top;

    localparam logic [11:0] SEL  = 12'h7A0;
    localparam logic [11:0] D1   = 12'h7A1;
    localparam logic [11:0] D2   = 12'h7A2;
    localparam logic [11:0] D3   = 12'h7A3;
    localparam logic [11:0] CAP  = 12'h7A4;
    localparam logic [11:0] MCX  = 12'h7A8;
    localparam logic [11:0] HOLE = 12'h7A5;
    localparam int NV = 18;

    // {write addr, write data, read addr, expected read, requirement number}
    localparam logic [95:0] VEC [NV] = '{
        {SEL, 32'h0000_0001, SEL, 32'h0000_0001, 8'd2},  // R2 accept 1
        {SEL, 32'h0000_0002, SEL, 32'h0000_0001, 8'd2},  // R2 reject 2
        {SEL, 32'hFFFF_FFFF, SEL, 32'h0000_0001, 8'd2},  // R2 reject huge
        {D1,  32'h2FFF_FFFF, D1,  32'h2003_005F, 8'd4},  // R4 type 2 masking
        {D1,  32'h6FFF_FFFF, D1,  32'h6180_005F, 8'd5},  // R5 type 6, size 15 dropped
        {D1,  32'h6005_0041, D1,  32'h6005_0041, 8'd6},  // R6 size 5 kept
        {D1,  32'h6004_0041, D1,  32'h6000_0041, 8'd6},  // R6 size 4 dropped
        {D1,  32'h9000_0007, D1,  32'h6000_0041, 8'd8},  // R8 unsupported type
        {D2,  32'hDEAD_BEEF, D2,  32'hDEAD_BEEF, 8'd9},  // R9 compare on type 6
        {D3,  32'hFFFF_FFFF, D3,  32'hFE00_0000, 8'd10}, // R10 keep 31:25
        {D3,  32'h0100_0000, D3,  32'h0000_0000, 8'd10}, // R10 selector 2 folds to 0
        {D1,  32'h3FFF_FFFF, D1,  32'h36FF_FEC0, 8'd7},  // R7 count type
        {D2,  32'h1234_5678, D2,  32'hDEAD_BEEF, 8'd9},  // R9 compare ignored on type 3
        {CAP, 32'h0000_0000, CAP, 32'h0000_0044, 8'd11}, // R11
        {SEL, 32'h0000_0000, D1,  32'h2000_0000, 8'd3},  // R3 trigger 0 untouched
        {HOLE,32'h0000_0055, D2,  32'h0000_0000, 8'd14}, // R14 hole write
        {MCX, 32'hFFFF_FFFF, MCX, 32'h0000_003F, 8'd12}, // R12
        {HOLE,32'h0000_0055, HOLE,32'h0000_0000, 8'd14}  // R14 hole read
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] ctrl_w, cmp_w;
    logic [5:0]  mctx;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    trig_csr_bank dut_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_we_i(we),
        .csr_wdata_i(wdata), .csr_rdata_o(rdata), .trig_ctrl_o(ctrl_w),
        .trig_cmp_o(cmp_w), .mctx_o(mctx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1 chk(req, rdata, exp);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1 reset values while held and after release
        rd_chk("R1", D1, 32'h2000_0000);
        @(negedge clk) rst_n = 1'b1;
        rd_chk("R1", SEL, 32'h0);
        rd_chk("R1", D2, 32'h0);
        rd_chk("R1", D3, 32'h0);
        rd_chk("R1", MCX, 32'h0);
        chk("R1", ctrl_w[63:32], 32'h2000_0000);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][95:84], VEC[i][83:52]);
            rd_chk($sformatf("R%0d vec%0d", VEC[i][7:0], i), VEC[i][51:40], VEC[i][39:8]);
        end

        // R13 exported words per trigger
        chk("R13 ctrl1", ctrl_w[63:32], 32'h36FF_FEC0);
        chk("R13 ctrl0", ctrl_w[31:0], 32'h2000_0000);
        chk("R13 cmp1", cmp_w[63:32], 32'hDEAD_BEEF);
        chk("R13 cmp0", cmp_w[31:0], 32'h0);
        chk("R12 port", {26'h0, mctx}, 32'h0000_003F);

        // R3 write timing: old value before the edge, new one after it
        @(negedge clk);
        addr = D2; we = 1'b1; wdata = 32'h0000_A5A5;
        #1 chk("R3 before edge", rdata, 32'h0);
        @(posedge clk);
        #1 chk("R3 after edge", rdata, 32'h0000_A5A5);
        @(negedge clk) we = 1'b0;
        chk("R3 other trigger", cmp_w[63:32], 32'hDEAD_BEEF);

        // R1 reset again from a dirty state
        wr(SEL, 32'h1);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R1 sel", SEL, 32'h0);
        rd_chk("R1 cmp", D2, 32'h0);
        chk("R1 ctrl1", ctrl_w[63:32], 32'h2000_0000);
        chk("R1 cmp1", cmp_w[63:32], 32'h0);
        chk("R1 mctx", {26'h0, mctx}, 32'h0);

        done = 1'b1;
        summary();
    end

endmodule